// File: doc/BRIEF.md
# I2C DMA Request and SMBus Alert Logic

This block sits between an I2C/SMBus byte engine and a system DMA controller. Only payload bytes cross the DMA path. Software programs the slave address, the direction, the byte total and the START condition, and the byte engine handles them. The block keeps two data-register flags: transmit holding register empty, and receive holding register full. From these flags it derives one DMA request line for each direction. Each request is gated by its own enable bit.

The end of the data phase comes from a loadable down-counter, not from the DMA controller. The counter steps down once for each byte that the engine completes. When a packet error check byte is used, it is counted inside the programmed total. It also leaves through the receive request like any other data byte. When the count reaches zero, no further transfers are requested until software loads the counter again.

In host mode the block also samples the active-low SMBus alert line. A falling edge sets a sticky alert flag, which feeds an error interrupt.

Top module: `i2c_dma_req_alert`

## Requirements
- R1: `dma_tx_req` is 1 only when all of the following hold: the transmit holding register is empty, the registered transmit enable is 1, the direction is transmit (`cfg_dir_rx`=0), and `bytes_left` is nonzero.
- R2: `dma_rx_req` is 1 only when the receive holding register is full and the registered receive enable is 1. It does not depend on `bytes_left`.
- R3: `txd_wr` marks the transmit register full and removes `dma_tx_req` in the same cycle. Either `dma_rx_ack` or `rxd_rd` marks the receive register empty and removes `dma_rx_req` in the same cycle.
- R4: `cnt_load` loads `cnt_value` into `bytes_left`. Each `eng_byte_done` with `bytes_left`≠0 decrements the count and sets the flag of the current direction. `eng_byte_done` at zero changes nothing. After a load, `xfer_done` is 1 while `bytes_left` is 0.
- R5: `pec_next` is 1 when `cfg_pec_en` is 1 and `bytes_left` is 1. On receive, the last counted byte (the check byte) raises `dma_rx_req` like any data byte.
- R6: `alert_flag` becomes 1 on the third rising clock edge after `smb_alert_n` falls, but only if `cfg_host_mode` and `cfg_alert_en` are both 1. Otherwise a falling edge has no effect.
- R7: `err_irq` is `alert_flag` gated by `cfg_err_ie`.
- R8: `alert_flag` holds until `alert_clr` is pulsed. If a clear and a new edge detection land in the same cycle, the flag stays 1.
- R9: Dropping a DMA enable removes the matching request on the next clock and leaves the flags untouched. Raising the enable again brings the request back one clock later.
- R10: After reset both requests are 0, `bytes_left`=0, `xfer_done`=0 and `alert_flag`=0. The transmit register reads as empty and the receive register as empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tx_dma_en | input | 1 | Transmit DMA enable |
| cfg_rx_dma_en | input | 1 | Receive DMA enable |
| cfg_dir_rx | input | 1 | Transfer direction, 1 = receive |
| cfg_pec_en | input | 1 | Packet error check byte in use |
| cfg_host_mode | input | 1 | SMBus host mode |
| cfg_alert_en | input | 1 | Alert line detection enable |
| cfg_err_ie | input | 1 | Error interrupt enable |
| cnt_load | input | 1 | Load byte counter |
| cnt_value | input | CNT_W | Byte total, check byte included |
| eng_byte_done | input | 1 | Byte engine finished one byte |
| txd_wr | input | 1 | Write of transmit data register (CPU or DMA) |
| rxd_rd | input | 1 | CPU read of receive data register |
| dma_rx_ack | input | 1 | DMA read of receive data register |
| smb_alert_n | input | 1 | SMBus alert line, active low, asynchronous |
| alert_clr | input | 1 | Write-1-to-clear of alert flag |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |
| bytes_left | output | CNT_W | Remaining byte count |
| xfer_done | output | 1 | Data phase complete |
| pec_next | output | 1 | Next byte is the check byte |
| alert_flag | output | 1 | Sticky alert flag |
| err_irq | output | 1 | Error interrupt |

## Verification
The assertions rely on several conditions at the block's inputs:
- `cnt_load` and `eng_byte_done` are never pulsed in the same cycle.
- `eng_byte_done` comes only for the direction selected by `cfg_dir_rx`.
- The alert line changes at most once per few cycles, so the synchronizer sees each level.

The stimulus follows the byte engine's order: it loads the counter, keeps the direction and enables steady during the data phase, and only stops completing bytes when the count is already zero. It holds each alert level for at least four clocks. It does let register accesses coincide with byte completions and clears coincide with detections, because the requirements define those cases.

// File: rtl/i2cdr_pkg.sv
package i2cdr_pkg;
   typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} xfer_dir_e;
   localparam int unsigned MIN_SYNC = 2;
endpackage

// File: rtl/i2cdr_byte_cnt.sv
module i2cdr_byte_cnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             byte_done,
   output logic             byte_ok,
   output logic             live,
   output logic             last,
   output logic             done,
   output logic [CNT_W-1:0] left
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;

   assign live    = (cnt_q != '0);
   assign byte_ok = byte_done & live;
   assign last    = (cnt_q == ONE);
   assign done    = armed_q & ~live;
   assign left    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         if (load) begin
            cnt_q   <= load_val;
            armed_q <= 1'b1;
         end else if (byte_ok) begin
            cnt_q <= cnt_q - ONE;
         end
      end
   end
endmodule

// File: rtl/i2cdr_req_gen.sv
module i2cdr_req_gen
   import i2cdr_pkg::*;
#(
   parameter bit EN_REG = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tx_en,
   input  logic      rx_en,
   input  xfer_dir_e dir,
   input  logic      byte_ok,
   input  logic      live,
   input  logic      txd_wr,
   input  logic      rx_take,
   output logic      tx_req,
   output logic      rx_req
);
   logic tx_en_eff, rx_en_eff;
   logic tx_empty_q, rx_full_q;

   generate
      if (EN_REG) begin : g_en_reg
         logic tx_en_q, rx_en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tx_en_q <= 1'b0;
               rx_en_q <= 1'b0;
            end else begin
               tx_en_q <= tx_en;
               rx_en_q <= rx_en;
            end
         end
         assign tx_en_eff = tx_en_q;
         assign rx_en_eff = rx_en_q;
      end else begin : g_en_comb
         assign tx_en_eff = tx_en;
         assign rx_en_eff = rx_en;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_empty_q <= 1'b1;
         rx_full_q  <= 1'b0;
      end else begin
         if (txd_wr)
            tx_empty_q <= 1'b0;
         else if (byte_ok && dir == DIR_TX)
            tx_empty_q <= 1'b1;
         if (byte_ok && dir == DIR_RX)
            rx_full_q <= 1'b1;
         else if (rx_take)
            rx_full_q <= 1'b0;
      end
   end

   assign tx_req = tx_empty_q & tx_en_eff & (dir == DIR_TX) & live & ~txd_wr;
   assign rx_req = rx_full_q & rx_en_eff & ~rx_take;
endmodule

// File: rtl/i2cdr_alert_det.sv
module i2cdr_alert_det #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic alert_n,
   input  logic arm,
   input  logic clr,
   output logic flag
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   flag_q;
   logic                   fall;

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sync_q[gi] <= 1'b1;
            else if (gi == 0)
               sync_q[gi] <= alert_n;
            else
               sync_q[gi] <= sync_q[(gi == 0) ? 0 : gi-1];
         end
      end
   endgenerate

   assign fall = prev_q & ~sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         flag_q <= 1'b0;
      end else begin
         prev_q <= sync_q[SYNC_STAGES-1];
         flag_q <= (fall & arm) | (flag_q & ~clr);
      end
   end

   assign flag = flag_q;
endmodule

// File: rtl/i2c_dma_req_alert.sv
module i2c_dma_req_alert
   import i2cdr_pkg::*;
#(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EN_REG      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_tx_dma_en,
   input  logic             cfg_rx_dma_en,
   input  logic             cfg_dir_rx,
   input  logic             cfg_pec_en,
   input  logic             cfg_host_mode,
   input  logic             cfg_alert_en,
   input  logic             cfg_err_ie,
   input  logic             cnt_load,
   input  logic [CNT_W-1:0] cnt_value,
   input  logic             eng_byte_done,
   input  logic             txd_wr,
   input  logic             rxd_rd,
   input  logic             dma_rx_ack,
   input  logic             smb_alert_n,
   input  logic             alert_clr,
   output logic             dma_tx_req,
   output logic             dma_rx_req,
   output logic [CNT_W-1:0] bytes_left,
   output logic             xfer_done,
   output logic             pec_next,
   output logic             alert_flag,
   output logic             err_irq
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (SYNC_STAGES < MIN_SYNC) begin : g_bad_sync
         $error("SYNC_STAGES below minimum");
      end
   endgenerate

   logic byte_ok, live, last;
   xfer_dir_e dir;

   assign dir = xfer_dir_e'(cfg_dir_rx);

   i2cdr_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cnt_load),
      .load_val  (cnt_value),
      .byte_done (eng_byte_done),
      .byte_ok   (byte_ok),
      .live      (live),
      .last      (last),
      .done      (xfer_done),
      .left      (bytes_left)
   );

   i2cdr_req_gen #(.EN_REG(EN_REG)) u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .tx_en   (cfg_tx_dma_en),
      .rx_en   (cfg_rx_dma_en),
      .dir     (dir),
      .byte_ok (byte_ok),
      .live    (live),
      .txd_wr  (txd_wr),
      .rx_take (rxd_rd | dma_rx_ack),
      .tx_req  (dma_tx_req),
      .rx_req  (dma_rx_req)
   );

   i2cdr_alert_det #(.SYNC_STAGES(SYNC_STAGES)) u_alert (
      .clk     (clk),
      .rst_n   (rst_n),
      .alert_n (smb_alert_n),
      .arm     (cfg_host_mode & cfg_alert_en),
      .clr     (alert_clr),
      .flag    (alert_flag)
   );

   assign pec_next = cfg_pec_en & last;
   assign err_irq  = alert_flag & cfg_err_ie;
endmodule

// File: rtl/i2cdr_dma_alert_chk.sv
module i2cdr_dma_alert_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_tx_dma_en,
   input logic             cfg_rx_dma_en,
   input logic             cfg_host_mode,
   input logic             cfg_alert_en,
   input logic             cnt_load,
   input logic             eng_byte_done,
   input logic             alert_clr,
   input logic             dma_tx_req,
   input logic             dma_rx_req,
   input logic [CNT_W-1:0] bytes_left,
   input logic             xfer_done,
   input logic             alert_flag
);
   AST_TX_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      dma_tx_req |-> $past(cfg_tx_dma_en)); // R1
   AST_RX_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      dma_rx_req |-> $past(cfg_rx_dma_en)); // R2
   AST_DONE_NO_TX_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> !dma_tx_req); // R4
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_load && eng_byte_done && bytes_left != '0)
         |=> (bytes_left == $past(bytes_left) - CNT_W'(1))); // R4
   AST_ALERT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alert_flag) |-> $past(cfg_host_mode && cfg_alert_en)); // R6
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (alert_flag && !alert_clr) |=> alert_flag); // R8
   AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rx_dma_en |=> !dma_rx_req); // R9
endmodule

bind i2c_dma_req_alert i2cdr_dma_alert_chk #(.CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_tx_dma_en (cfg_tx_dma_en),
   .cfg_rx_dma_en (cfg_rx_dma_en),
   .cfg_host_mode (cfg_host_mode),
   .cfg_alert_en  (cfg_alert_en),
   .cnt_load      (cnt_load),
   .eng_byte_done (eng_byte_done),
   .alert_clr     (alert_clr),
   .dma_tx_req    (dma_tx_req),
   .dma_rx_req    (dma_rx_req),
   .bytes_left    (bytes_left),
   .xfer_done     (xfer_done),
   .alert_flag    (alert_flag)
);

// File: tb/sim_i2c_dma_req_alert.sv
`timescale 1ns/1ps
module sim_i2c_dma_req_alert;
   localparam int CW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_tx_dma_en = 0, cfg_rx_dma_en = 0, cfg_dir_rx = 0, cfg_pec_en = 0;
   logic cfg_host_mode = 0, cfg_alert_en = 0, cfg_err_ie = 0;
   logic cnt_load = 0;
   logic [CW-1:0] cnt_value = '0;
   logic eng_byte_done = 0, txd_wr = 0, rxd_rd = 0, dma_rx_ack = 0;
   logic smb_alert_n = 1, alert_clr = 0;
   logic dma_tx_req, dma_rx_req, xfer_done, pec_next, alert_flag, err_irq;
   logic [CW-1:0] bytes_left;

   int checks = 0;
   int failures = 0;

   // reference model state
   int m_cnt;
   bit m_armed, m_txe, m_rxf, m_en_tx, m_en_rx, m_flag;
   bit m_hist[$];

   always #5 clk = ~clk;

   i2c_dma_req_alert #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_tx_dma_en(cfg_tx_dma_en), .cfg_rx_dma_en(cfg_rx_dma_en),
      .cfg_dir_rx(cfg_dir_rx), .cfg_pec_en(cfg_pec_en),
      .cfg_host_mode(cfg_host_mode), .cfg_alert_en(cfg_alert_en),
      .cfg_err_ie(cfg_err_ie), .cnt_load(cnt_load), .cnt_value(cnt_value),
      .eng_byte_done(eng_byte_done), .txd_wr(txd_wr), .rxd_rd(rxd_rd),
      .dma_rx_ack(dma_rx_ack), .smb_alert_n(smb_alert_n), .alert_clr(alert_clr),
      .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .bytes_left(bytes_left),
      .xfer_done(xfer_done), .pec_next(pec_next), .alert_flag(alert_flag),
      .err_irq(err_irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_cnt = 0; m_armed = 0; m_txe = 1; m_rxf = 0;
      m_en_tx = 0; m_en_rx = 0; m_flag = 0;
      m_hist = {1'b1, 1'b1, 1'b1};
   endtask

   task automatic compare();
      bit take;
      take = rxd_rd | dma_rx_ack;
      chk("R1 dma_tx_req", dma_tx_req,
          int'(m_txe && m_en_tx && !cfg_dir_rx && m_cnt != 0 && !txd_wr));
      chk("R2 dma_rx_req", dma_rx_req, int'(m_rxf && m_en_rx && !take));
      chk("R4 bytes_left", bytes_left, m_cnt);
      chk("R4 xfer_done", xfer_done, int'(m_armed && m_cnt == 0));
      chk("R5 pec_next", pec_next, int'(cfg_pec_en && m_cnt == 1));
      chk("R6 alert_flag", alert_flag, int'(m_flag));
      chk("R7 err_irq", err_irq, int'(m_flag && cfg_err_ie));
   endtask

   task automatic model_clock();
      bit ok, fall;
      ok = eng_byte_done && m_cnt != 0;
      if (txd_wr) m_txe = 0;
      else if (ok && !cfg_dir_rx) m_txe = 1;
      if (ok && cfg_dir_rx) m_rxf = 1;
      else if (rxd_rd || dma_rx_ack) m_rxf = 0;
      if (cnt_load) begin m_cnt = int'(cnt_value); m_armed = 1; end
      else if (ok) m_cnt = m_cnt - 1;
      m_en_tx = cfg_tx_dma_en;
      m_en_rx = cfg_rx_dma_en;
      fall = m_hist[$-2] && !m_hist[$-1];
      m_flag = (fall && cfg_host_mode && cfg_alert_en) || (m_flag && !alert_clr);
      m_hist.push_back(smb_alert_n);
      void'(m_hist.pop_front());
   endtask

   // inputs are already set (after a falling edge); compare, clock, return after next falling edge
   task automatic step();
      #1 compare();
      @(posedge clk);
      model_clock();
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic pulse_byte();
      eng_byte_done = 1; step(); eng_byte_done = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      // R10: reset state
      #1;
      chk("R10 tx_req", dma_tx_req, 0);
      chk("R10 rx_req", dma_rx_req, 0);
      chk("R10 bytes_left", bytes_left, 0);
      chk("R10 done", xfer_done, 0);
      chk("R10 flag", alert_flag, 0);
      @(negedge clk);
      rst_n = 1;
      idle(2);

      // transmit transfer of 3 bytes
      cfg_dir_rx = 0; cfg_tx_dma_en = 1;
      cnt_value = 8'd3; cnt_load = 1; step(); cnt_load = 0;
      step();
      #1 chk("R1 tx request after load", dma_tx_req, 1);
      txd_wr = 1;
      #1 chk("R3 write removes tx request same cycle", dma_tx_req, 0);
      step(); txd_wr = 0;
      idle(2);
      pulse_byte();
      txd_wr = 1; pulse_byte(); txd_wr = 0;  // write coincides with byte completion
      idle(1);
      pulse_byte();
      txd_wr = 1; step(); txd_wr = 0;
      pulse_byte();
      #1 chk("R4 done after last tx byte", xfer_done, 1);
      chk("R4 no tx request at zero", dma_tx_req, 0);
      pulse_byte();  // ignored at zero
      #1 chk("R4 byte at zero ignored", bytes_left, 0);
      cfg_tx_dma_en = 0;
      idle(1);

      // receive transfer with check byte, total 3
      cfg_dir_rx = 1; cfg_rx_dma_en = 1; cfg_pec_en = 1;
      cnt_value = 8'd3; cnt_load = 1; step(); cnt_load = 0;
      idle(1);
      pulse_byte();
      #1 chk("R2 rx request after byte", dma_rx_req, 1);
      dma_rx_ack = 1;
      #1 chk("R3 ack removes rx request same cycle", dma_rx_req, 0);
      step(); dma_rx_ack = 0;
      pulse_byte();
      #1 chk("R5 pec_next with one byte left", pec_next, 1);
      rxd_rd = 1; step(); rxd_rd = 0;
      pulse_byte();
      #1 chk("R5 check byte raises rx request", dma_rx_req, 1);
      chk("R4 rx done", xfer_done, 1);
      // R9: disable while full
      cfg_rx_dma_en = 0; step();
      #1 chk("R9 rx request drops next clock", dma_rx_req, 0);
      idle(2);
      cfg_rx_dma_en = 1; step();
      #1 chk("R9 flag kept, request returns", dma_rx_req, 1);
      dma_rx_ack = 1; step(); dma_rx_ack = 0;
      pulse_byte();  // past zero, no new request
      #1 chk("R4 no rx request after completion", dma_rx_req, 0);
      cfg_pec_en = 0;
      idle(1);

      // alert: host mode off
      cfg_alert_en = 1; cfg_host_mode = 0;
      smb_alert_n = 0; idle(5);
      smb_alert_n = 1; idle(5);
      #1 chk("R6 no flag without host mode", alert_flag, 0);
      // detection off
      cfg_host_mode = 1; cfg_alert_en = 0;
      smb_alert_n = 0; idle(5);
      smb_alert_n = 1; idle(5);
      #1 chk("R6 no flag without detection", alert_flag, 0);
      // armed: flag on third edge
      cfg_alert_en = 1;
      smb_alert_n = 0; idle(2);
      #1 chk("R6 flag not yet after two edges", alert_flag, 0);
      step();
      #1 chk("R6 flag after third edge", alert_flag, 1);
      chk("R7 irq gated off", err_irq, 0);
      cfg_err_ie = 1;
      #1 chk("R7 irq enabled", err_irq, 1);
      idle(2);
      alert_clr = 1; step(); alert_clr = 0;
      #1 chk("R8 w1c clears flag", alert_flag, 0);
      smb_alert_n = 1; idle(4);
      // clear coinciding with a new detection
      smb_alert_n = 0; idle(2);
      alert_clr = 1; step(); alert_clr = 0;
      #1 chk("R8 set wins over clear", alert_flag, 1);
      idle(3);
      #1 chk("R8 flag sticky", alert_flag, 1);
      smb_alert_n = 1;
      alert_clr = 1; step(); alert_clr = 0;
      idle(4);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule